// File: doc/BRIEF.md
# Serial Byte Transmitter with Line-Driver Enable

This block is a transmit-only asynchronous serial port. Each accepted request sends one byte as a frame made of a low start bit, the data bits with the least significant bit first, and a high stop bit. There is no parity. The serial line is reached through an external driver, and a dedicated active-low enable output switches that driver on only for the length of a transmission.

A request is a one-cycle `send` strobe with the byte on `tx_data`. The enable goes low one clock before the start bit appears. It stays low until the stop bit has completely left the shift register, not merely until the byte has moved out of the holding register. While a frame is in flight, `busy` is high and any further strobes are dropped. A new request is taken in the very cycle after `busy` falls.

Bit timing comes from a divider that reloads itself on every underflow, followed by a prescaler. With the defaults, a 2 MHz clock, a reload value of 25 and a prescale of 16 give a bit period of T = (25+1)*16 = 416 clocks, which is about 4800 baud.

Top module: `serial_tx_de`

## Requirements
- R1: Out of reset, and at all times when not busy, `txd` = 1, `drv_en_n` = 1 and `busy` = 0. A reset during a frame returns the block to this state at once.
- R2: A `send` strobe sampled while `busy` = 0 is accepted. In the next cycle `busy` = 1 and `drv_en_n` = 0, while `txd` is still 1 for exactly that one cycle, so the enable comes before the frame.
- R3: The start bit (`txd` = 0) begins 1 cycle after the accepting edge and lasts T = (DIV_RELOAD+1)*PRESCALE clocks.
- R4: Data bit k (k = 0 for the least significant bit) is driven for T clocks, starting 1+(k+1)*T cycles after the accepting edge. `txd` changes only on these bit boundaries.
- R5: The stop bit (`txd` = 1) follows the last data bit for T clocks.
- R6: `drv_en_n` returns to 1 and `busy` to 0 exactly 1+10*T cycles after the accepting edge, once the stop bit has fully drained, and not before.
- R7: A `send` strobe while `busy` = 1 is ignored. The frame in flight is unchanged and no further frame follows it.
- R8: The byte is captured at the accepting edge. Later changes to `tx_data` do not alter the frame in flight.
- R9: A strobe in the first cycle with `busy` = 0 after a frame is accepted, so frames can run back to back.
- R10: `txd` is never 0 while `drv_en_n` = 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock (2 MHz nominal) |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_data | input | DATA_BITS | Byte to send, sampled on an accepted strobe |
| send | input | 1 | One-cycle transmit request |
| txd | output | 1 | Serial data line, idles high |
| drv_en_n | output | 1 | Active-low enable for the external line driver |
| busy | output | 1 | High from acceptance until the driver is released |

## Verification
Two kinds of internal fault show at the ports. A wrong divider or prescaler count moves every bit edge away from a multiple of T after the frame start, so it is visible at the first data-bit boundary, T+1 cycles after acceptance. A wrong shift count or drain condition releases `drv_en_n` early or late against the 1+10*T point. Early release would cut the stop bit or leave `txd` low with the driver off, and that shows within the same frame. A holding register that is loaded while busy corrupts the data bits that follow the stray strobe, or starts an unwanted frame within one T.

// File: rtl/serial_tx_pkg.sv
package serial_tx_pkg;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_ARM   = 2'd1,
      ST_SHIFT = 2'd2
   } tx_state_e;

   function automatic int unsigned frame_len(input int unsigned data_bits,
                                             input int unsigned stop_bits);
      return data_bits + 1 + stop_bits;
   endfunction

endpackage

// File: rtl/serial_tx_baud.sv
module serial_tx_baud #(
   parameter int unsigned DIV_RELOAD = 25,
   parameter int unsigned PRESCALE   = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic restart,
   output logic tick
);
   localparam int DW = (DIV_RELOAD > 0) ? $clog2(DIV_RELOAD + 1) : 1;

   logic          pre_wrap;
   logic [DW-1:0] div_q;

   generate
      if (PRESCALE > 1) begin : g_pre
         localparam int PW = $clog2(PRESCALE);
         logic [PW-1:0] pre_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)        pre_q <= '0;
            else if (restart)  pre_q <= '0;
            else if (pre_wrap) pre_q <= '0;
            else               pre_q <= pre_q + 1'b1;
         end
         assign pre_wrap = (pre_q == PW'(PRESCALE - 1));
      end else begin : g_nopre
         assign pre_wrap = 1'b1;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        div_q <= DW'(DIV_RELOAD);
      else if (restart)  div_q <= DW'(DIV_RELOAD);
      else if (pre_wrap) div_q <= (div_q == '0) ? DW'(DIV_RELOAD) : div_q - 1'b1;
   end

   assign tick = pre_wrap && (div_q == '0);

endmodule

// File: rtl/serial_tx_shifter.sv
module serial_tx_shifter #(
   parameter int unsigned DATA_BITS = 8,
   parameter int unsigned STOP_BITS = 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 load,
   input  logic [DATA_BITS-1:0] byte_in,
   input  logic                 tick,
   output logic                 txd,
   output logic                 drained
);
   localparam int FRAME = serial_tx_pkg::frame_len(DATA_BITS, STOP_BITS);
   localparam int CW    = $clog2(FRAME + 1);

   logic [FRAME-1:0] sh_q;
   logic [CW-1:0]    left_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_q   <= '1;
         left_q <= '0;
      end else if (load) begin
         sh_q   <= {{STOP_BITS{1'b1}}, byte_in, 1'b0};
         left_q <= CW'(FRAME);
      end else if (tick && (left_q != '0)) begin
         sh_q   <= {1'b1, sh_q[FRAME-1:1]};
         left_q <= left_q - 1'b1;
      end
   end

   assign txd     = (left_q != '0) ? sh_q[0] : 1'b1;
   assign drained = tick && (left_q == CW'(1));

endmodule

// File: rtl/serial_tx_ctrl.sv
module serial_tx_ctrl #(
   parameter int unsigned DATA_BITS = 8
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 send,
   input  logic [DATA_BITS-1:0] data_in,
   input  logic                 drained,
   output logic [DATA_BITS-1:0] hold_q,
   output logic                 arm,
   output logic                 drv_en_n,
   output logic                 busy
);
   import serial_tx_pkg::*;

   tx_state_e state_q, state_d;

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_IDLE:  if (send) state_d = ST_ARM;
         ST_ARM:   state_d = ST_SHIFT;
         ST_SHIFT: if (drained) state_d = ST_IDLE;
         default:  state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         hold_q  <= '0;
      end else begin
         state_q <= state_d;
         if ((state_q == ST_IDLE) && send) hold_q <= data_in;
      end
   end

   assign arm      = (state_q == ST_ARM);
   assign busy     = (state_q != ST_IDLE);
   assign drv_en_n = (state_q == ST_IDLE);

endmodule

// File: rtl/serial_tx_de.sv
module serial_tx_de #(
   parameter int unsigned DATA_BITS  = 8,
   parameter int unsigned STOP_BITS  = 1,
   parameter int unsigned DIV_RELOAD = 25,
   parameter int unsigned PRESCALE   = 16
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [DATA_BITS-1:0] tx_data,
   input  logic                 send,
   output logic                 txd,
   output logic                 drv_en_n,
   output logic                 busy
);
   initial begin
      assert (DATA_BITS >= 5 && DATA_BITS <= 9) else $error("DATA_BITS out of range");
      assert (STOP_BITS >= 1 && STOP_BITS <= 2) else $error("STOP_BITS out of range");
      assert (PRESCALE >= 1) else $error("PRESCALE must be at least 1");
      assert ((DIV_RELOAD + 1) * PRESCALE >= 2) else $error("bit period too short");
   end

   logic [DATA_BITS-1:0] hold;
   logic                 arm;
   logic                 tick;
   logic                 drained;

   serial_tx_ctrl #(.DATA_BITS(DATA_BITS)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .send(send), .data_in(tx_data),
      .drained(drained), .hold_q(hold), .arm(arm),
      .drv_en_n(drv_en_n), .busy(busy)
   );

   serial_tx_baud #(.DIV_RELOAD(DIV_RELOAD), .PRESCALE(PRESCALE)) u_baud (
      .clk(clk), .rst_n(rst_n), .restart(arm), .tick(tick)
   );

   serial_tx_shifter #(.DATA_BITS(DATA_BITS), .STOP_BITS(STOP_BITS)) u_shift (
      .clk(clk), .rst_n(rst_n), .load(arm), .byte_in(hold),
      .tick(tick), .txd(txd), .drained(drained)
   );

endmodule

// File: rtl/serial_tx_de_chk.sv
module serial_tx_de_chk #(
   parameter int unsigned DATA_BITS  = 8,
   parameter int unsigned STOP_BITS  = 1,
   parameter int unsigned DIV_RELOAD = 25,
   parameter int unsigned PRESCALE   = 16
) (
   input logic clk,
   input logic rst_n,
   input logic send,
   input logic txd,
   input logic drv_en_n,
   input logic busy
);
   localparam int FRAME = serial_tx_pkg::frame_len(DATA_BITS, STOP_BITS);
   localparam int BIT_T = (DIV_RELOAD + 1) * PRESCALE;
   localparam int FW    = $clog2(FRAME * BIT_T + 2) + 1;

   logic [FW-1:0] fc;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        fc <= '0;
      else if (drv_en_n) fc <= '0;
      else if (fc != '1) fc <= fc + 1'b1;
   end

   assert_idle_high_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (txd && drv_en_n));

   assert_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (send && !busy) |=> (busy && !drv_en_n && txd));

   assert_bit_boundary_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!drv_en_n && !$past(drv_en_n) && (txd != $past(txd)))
         |-> (((int'(fc) - 1) % BIT_T) == 0));

   assert_release_at_end_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(drv_en_n) |-> (int'(fc) == 1 + FRAME * BIT_T));

   assert_line_enabled_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !txd |-> !drv_en_n);

endmodule

bind serial_tx_de serial_tx_de_chk #(
   .DATA_BITS(DATA_BITS), .STOP_BITS(STOP_BITS),
   .DIV_RELOAD(DIV_RELOAD), .PRESCALE(PRESCALE)
) u_chk (
   .clk(clk), .rst_n(rst_n), .send(send), .txd(txd),
   .drv_en_n(drv_en_n), .busy(busy)
);

// File: tb/serial_tx_de_tb.sv
module serial_tx_de_tb;
   localparam int RELOAD = 25;
   localparam int PRE    = 16;
   localparam int BIT_T  = (RELOAD + 1) * PRE;
   localparam int FRAME  = 10;
   localparam int NVEC   = 6;
   // {back_to_back, disturb_mid_frame, byte}
   localparam logic [9:0] VEC [NVEC] = '{
      {1'b0, 1'b0, 8'h55},
      {1'b1, 1'b0, 8'hA5},
      {1'b0, 1'b1, 8'h00},
      {1'b1, 1'b0, 8'hFF},
      {1'b0, 1'b1, 8'h81},
      {1'b1, 1'b0, 8'h3C}
   };

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] tx_data = 8'h00;
   logic       send = 1'b0;
   logic       txd, drv_en_n, busy;
   int         errors = 0;
   int         checks = 0;
   int         n = 0;

   always #2 clk = ~clk;

   serial_tx_de u_dut (
      .clk(clk), .rst_n(rst_n), .tx_data(tx_data), .send(send),
      .txd(txd), .drv_en_n(drv_en_n), .busy(busy)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic adv(input int target);
      repeat (target - n) @(posedge clk);
      @(negedge clk);
      n = target;
   endtask

   task automatic run_frame(input logic [7:0] b, input bit disturb, input bit b2b);
      logic expb;
      string req;
      tx_data = b;
      send = 1'b1;
      @(posedge clk);
      @(negedge clk);
      send = 1'b0;
      n = 0;
      chk({drv_en_n, busy, txd} == 3'b011, b2b ? "R9" : "R2",
          {drv_en_n, busy, txd}, 3'b011);
      for (int j = 0; j < FRAME; j++) begin
         adv(1 + j * BIT_T + BIT_T / 2);
         if (j == 0) begin
            expb = 1'b0; req = "R3";
         end else if (j <= 8) begin
            expb = b[j-1]; req = disturb ? "R4/R8" : "R4";
         end else begin
            expb = 1'b1; req = "R5";
         end
         chk(txd == expb, req, txd, expb);
         if (j == 0) chk(drv_en_n == 1'b0, "R10", drv_en_n, 0);
         if (disturb && j == 3) begin
            tx_data = ~b;
            send = 1'b1;
            @(posedge clk);
            @(negedge clk);
            send = 1'b0;
            n++;
            chk(busy && !drv_en_n, "R7", {busy, drv_en_n}, 2'b10);
         end
      end
      adv(FRAME * BIT_T);
      chk(!drv_en_n && busy, "R6", {drv_en_n, busy}, 2'b01);
      adv(1 + FRAME * BIT_T);
      chk({drv_en_n, busy, txd} == 3'b101, "R6", {drv_en_n, busy, txd}, 3'b101);
   endtask

   initial begin : watchdog
      repeat (190000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin : main
      bit ok;
      repeat (3) @(negedge clk);
      chk({txd, drv_en_n, busy} == 3'b110, "R1", {txd, drv_en_n, busy}, 3'b110);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      chk({txd, drv_en_n, busy} == 3'b110, "R1", {txd, drv_en_n, busy}, 3'b110);

      for (int v = 0; v < NVEC; v++) begin
         if (!VEC[v][9]) repeat (7) @(negedge clk);
         run_frame(VEC[v][7:0], VEC[v][8], VEC[v][9]);
         if (VEC[v][8]) begin
            ok = 1'b1;
            for (int s = 0; s < 64; s++) begin
               repeat (13) @(negedge clk);
               if (!(txd && drv_en_n && !busy)) ok = 1'b0;
            end
            chk(ok, "R7", {txd, drv_en_n, busy}, 3'b110);
         end
      end

      // reset in the middle of a frame
      tx_data = 8'h00;
      send = 1'b1;
      @(negedge clk);
      send = 1'b0;
      repeat (3 * BIT_T) @(negedge clk);
      chk(!txd && !drv_en_n, "R1", {txd, drv_en_n}, 2'b00);
      rst_n = 1'b0;
      @(negedge clk);
      chk({txd, drv_en_n, busy} == 3'b110, "R1", {txd, drv_en_n, busy}, 3'b110);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);
      run_frame(8'hC3, 1'b0, 1'b0);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule